// File: doc/BRIEF.md
# Clock Loss Failover Switch

This block supervises a primary clock, which may come from a frequency synthesizer or straight from an external clock pin, using a free-running backup oscillator clock. The backup clock times the supervision and is also the clock the block falls back to. The block drives a system clock that the rest of the chip runs on. When the primary clock stops, the system clock moves to the backup clock with no runt pulse. A sticky limp flag goes high and a one-cycle event pulse marks the loss. When primary edges come back, the block returns to the primary source by itself.

Activity is measured with a ping/echo round trip. The backup domain flips a ping bit. The primary domain resynchronises the ping and echoes it back. Every echo that completes counts as proof that the primary clock is alive. At power-up the system clock comes from the backup source. Only after a run of completed echoes does the block hand over to the primary clock. Each change of source is break-before-make. The old gate closes first, and the new gate opens only after two falling edges of the new clock. When the primary returns in synthesizer mode, a flag shows that the synthesizer is still unlocked for a fixed number of backup cycles.

Top module: `clk_loss_failover`

## Requirements
- R1: While `rst_n` is low, and after reset for as long as the primary clock has not been recognised, `sys_clk` follows `bak_clk`. `limp`, `loc_pulse` and `pll_unlocked` are 0 after reset.
- R2: Once RECOVER_HS (default 2) consecutive ping/echo round trips complete, the block hands `sys_clk` over to `pri_clk`. Before that, `sys_clk` is low for the break interval.
- R3: While running on the primary with `det_en` = 1, a round trip that stays open for LOC_TIMEOUT (default 8) backup cycles declares loss, and `sys_clk` moves back to `bak_clk`. A primary stall of two backup cycles or less never declares loss.
- R4: Each loss produces exactly one `loc_pulse` that is one backup cycle wide.
- R5: `limp` goes to 1 on the first loss. It stays 1 through any later return to the primary and is cleared only by reset.
- R6: After a loss, `sys_clk` goes back to `pri_clk` without any outside action once the primary clock runs again.
- R7: When the block returns to the primary after a loss with `pll_mode` = 1, `pll_unlocked` is 1 for exactly RELOCK_CYC (default 16) backup cycles. It stays 0 when `pll_mode` = 0, and it stays 0 on the first hand-over after reset.
- R8: While `det_en` = 0, no loss is declared. `limp` and `loc_pulse` do not change, and `sys_clk` stays on the primary even if the primary stops.
- R9: `sys_clk` never shows a high or low phase shorter than the shorter half period of the two sources. The two source gates are never open at the same time.
- R10: Loss detection and return behave the same for `pll_mode` = 0 and `pll_mode` = 1. Only `pll_unlocked` depends on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pri_clk | input | 1 | Primary clock (synthesizer output or external clock) |
| bak_clk | input | 1 | Free-running backup clock, timebase of the detector |
| rst_n | input | 1 | Active-low reset, synchronous in the backup domain |
| pll_mode | input | 1 | 1: primary comes from the synthesizer; 0: external clock |
| det_en | input | 1 | 1 enables declaring loss of the primary clock |
| sys_clk | output | 1 | Glitch-free system clock |
| limp | output | 1 | Sticky flag, set on the first loss |
| loc_pulse | output | 1 | One backup-cycle pulse for each loss |
| pll_unlocked | output | 1 | Synthesizer-relocking window after a return in PLL mode |

## Verification
A ping/echo counter that is stuck or misses completions shows up at the ports in two ways. Either a short primary stall raises `loc_pulse` and `limp` within about ten backup cycles, or a long stall leaves `sys_clk` frozen with no pulse. A gate select that is wrong shows as a runt phase on `sys_clk`, or as the edge count of `sys_clk` matching the wrong source within one measurement window of about 25 backup cycles. Relock-counter and mode errors change how many backup cycles `pll_unlocked` is high, and that count is visible within one window after the return. To catch errors that only appear in some combinations, the stimulus sweeps stall length, the level the primary stops at, and the mode.

// File: rtl/loc_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock loss failover switch.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package loc_pkg;

    // Status handed from the activity monitor to the controller (backup domain).
    typedef struct packed {
        logic hs_ok;    // a ping/echo round trip completes this cycle
        logic stalled;  // the open round trip has hit the timeout
    } act_stat_t;

    // Which source drives the system clock; used for readability in checks.
    typedef enum logic {
        SRC_BACKUP  = 1'b0,
        SRC_PRIMARY = 1'b1
    } clk_src_e;

endpackage

// File: rtl/loc_activity_mon.sv
`timescale 1ns/1ps
// Primary clock activity monitor.
// The backup domain flips a ping bit. The primary domain resynchronises
// it and echoes it back, and the backup domain resynchronises the echo.
// A completed round trip proves primary edges exist. The idle counter
// measures how long the current round trip has been open.
// Assumes: the primary runs fast enough for a round trip to finish well
// inside LOC_TIMEOUT backup cycles. Primary-domain flops clear
// asynchronously because the primary may be dead during reset.
module loc_activity_mon
    import loc_pkg::*;
#(
    parameter int LOC_TIMEOUT = 8
) (
    input  logic      bak_clk,
    input  logic      pri_clk,
    input  logic      rst_n,
    output act_stat_t stat
);
    localparam int CW = $clog2(LOC_TIMEOUT + 1);

    logic          ping;
    logic          ping_p1, ping_p2, echo;
    logic          echo_b1, echo_b2;
    logic [CW-1:0] idle_cnt;
    logic          trip_done;

    // Primary domain: resynchronise the ping and return it as the echo.
    always_ff @(posedge pri_clk or negedge rst_n) begin
        if (!rst_n) begin
            ping_p1 <= 1'b0;
            ping_p2 <= 1'b0;
            echo    <= 1'b0;
        end else begin
            ping_p1 <= ping;
            ping_p2 <= ping_p1;
            echo    <= ping_p2;
        end
    end

    assign trip_done = (echo_b2 == ping);

    // Backup domain: resynchronise the echo, launch the next ping, time the open trip.
    always_ff @(posedge bak_clk) begin
        if (!rst_n) begin
            ping     <= 1'b1;
            echo_b1  <= 1'b0;
            echo_b2  <= 1'b0;
            idle_cnt <= '0;
        end else begin
            echo_b1 <= echo;
            echo_b2 <= echo_b1;
            if (trip_done) begin
                ping     <= ~ping;
                idle_cnt <= '0;
            end else if (idle_cnt != CW'(LOC_TIMEOUT)) begin
                idle_cnt <= idle_cnt + 1'b1;
            end
        end
    end

    assign stat.hs_ok   = trip_done;
    assign stat.stalled = (idle_cnt == CW'(LOC_TIMEOUT));

    // A new ping cannot be echoed in the cycle right after it launches.
    AST_TRIP_SPACED: assert property (@(posedge bak_clk) disable iff (!rst_n)
        stat.hs_ok |=> !stat.hs_ok);  // R2
    // A completed trip means the timeout is not pending on the next cycle.
    AST_TRIP_CLEARS_STALL: assert property (@(posedge bak_clk) disable iff (!rst_n)
        stat.hs_ok |=> !stat.stalled);  // R3

endmodule

// File: rtl/loc_ctrl.sv
`timescale 1ns/1ps
// Failover controller in the backup clock domain.
// Keeps the "primary alive" decision, the sticky limp flag, the loss
// event pulse and the synthesizer relock window.
// Assumes: stat comes from loc_activity_mon and is already in the backup domain.
module loc_ctrl
    import loc_pkg::*;
#(
    parameter int RECOVER_HS = 2,
    parameter int RELOCK_CYC = 16
) (
    input  logic      bak_clk,
    input  logic      rst_n,
    input  logic      det_en,
    input  logic      pll_mode,
    input  act_stat_t stat,
    output logic      alive,
    output logic      limp,
    output logic      loc_pulse,
    output logic      pll_unlocked
);
    localparam int GW = $clog2(RECOVER_HS + 1);
    localparam int RW = $clog2(RELOCK_CYC + 1);

    logic [GW-1:0] good_cnt;
    logic [RW-1:0] relock_cnt;

    // Decide the source state, flag losses and time the relock window.
    always_ff @(posedge bak_clk) begin
        if (!rst_n) begin
            alive        <= 1'b0;
            limp         <= 1'b0;
            loc_pulse    <= 1'b0;
            pll_unlocked <= 1'b0;
            good_cnt     <= '0;
            relock_cnt   <= '0;
        end else begin
            loc_pulse <= 1'b0;
            if (pll_unlocked) begin
                if (relock_cnt == RW'(RELOCK_CYC - 1)) begin
                    pll_unlocked <= 1'b0;
                end else begin
                    relock_cnt <= relock_cnt + 1'b1;
                end
            end
            if (alive) begin
                if (det_en && stat.stalled && !stat.hs_ok) begin
                    alive        <= 1'b0;
                    limp         <= 1'b1;
                    loc_pulse    <= 1'b1;
                    good_cnt     <= '0;
                    pll_unlocked <= 1'b0;
                end
            end else if (stat.hs_ok) begin
                if (good_cnt == GW'(RECOVER_HS - 1)) begin
                    alive    <= 1'b1;
                    good_cnt <= '0;
                    if (limp && pll_mode) begin
                        pll_unlocked <= 1'b1;
                        relock_cnt   <= '0;
                    end
                end else begin
                    good_cnt <= good_cnt + 1'b1;
                end
            end else if (stat.stalled) begin
                good_cnt <= '0;
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge bak_clk) disable iff (!rst_n)
        loc_pulse |=> !loc_pulse);  // R4
    AST_PULSE_MARKS_LIMP: assert property (@(posedge bak_clk) disable iff (!rst_n)
        loc_pulse |-> (limp && !alive));  // R3
    AST_LIMP_STICKY: assert property (@(posedge bak_clk) disable iff (!rst_n)
        limp |=> limp);  // R5
    AST_DISABLED_NO_LOSS: assert property (@(posedge bak_clk) disable iff (!rst_n)
        $fell(alive) |-> $past(det_en));  // R8
    AST_UNLOCK_ONLY_PLL: assert property (@(posedge bak_clk) disable iff (!rst_n)
        $rose(pll_unlocked) |-> ($past(pll_mode) && $rose(alive)));  // R7

endmodule

// File: rtl/loc_glitchfree_mux.sv
`timescale 1ns/1ps
// Break-before-make clock selector.
// Each source has a two-flop gate chain clocked on that source's falling
// edge. It opens only once the other gate is seen closed. The primary
// gate closes asynchronously when the primary is no longer wanted,
// because a dead clock cannot clock its own gate shut.
// Assumes: want_pri is a backup-domain register output.
module loc_glitchfree_mux (
    input  logic pri_clk,
    input  logic bak_clk,
    input  logic rst_n,
    input  logic want_pri,
    output logic sys_clk,
    output logic pri_sel,
    output logic bak_sel
);
    logic kill;
    logic pg1, pg2;
    logic pri_seen1, pri_seen2;
    logic bg1, bg2;

    assign kill = ~want_pri | ~rst_n;

    // Primary gate: open two primary falling edges after the backup gate is closed.
    always_ff @(negedge pri_clk or posedge kill) begin
        if (kill) begin
            pg1 <= 1'b0;
            pg2 <= 1'b0;
        end else begin
            pg1 <= ~bak_sel;
            pg2 <= pg1;
        end
    end

    // Bring the primary gate state into the backup domain.
    always_ff @(posedge bak_clk) begin
        if (!rst_n) begin
            pri_seen1 <= 1'b0;
            pri_seen2 <= 1'b0;
        end else begin
            pri_seen1 <= pg2;
            pri_seen2 <= pri_seen1;
        end
    end

    // Backup gate: open in reset, or two backup falling edges after the primary gate is seen closed.
    always_ff @(negedge bak_clk) begin
        if (!rst_n) begin
            bg1 <= 1'b1;
            bg2 <= 1'b1;
        end else begin
            bg1 <= ~want_pri & ~pri_seen2;
            bg2 <= bg1;
        end
    end

    assign pri_sel = pg2;
    assign bak_sel = bg2;
    assign sys_clk = (pri_clk & pri_sel) | (bak_clk & bak_sel);

    AST_BREAK_BEFORE_MAKE: assert property (@(posedge bak_clk) disable iff (!rst_n)
        !(pri_sel && bak_sel));  // R9
    AST_UNWANTED_CLOSED: assert property (@(posedge bak_clk) disable iff (!rst_n)
        !want_pri |-> !pri_sel);  // R3

endmodule

// File: rtl/clk_loss_failover.sv
`timescale 1ns/1ps
// Clock loss failover switch, top level.
// Connects the activity monitor, the controller and the glitch-free
// selector. The system clock starts on the backup source and follows
// the primary only while the controller judges the primary alive.
// Assumes: bak_clk runs whenever the block must work, including reset.
module clk_loss_failover
    import loc_pkg::*;
#(
    parameter int LOC_TIMEOUT = 8,
    parameter int RECOVER_HS  = 2,
    parameter int RELOCK_CYC  = 16
) (
    input  logic pri_clk,
    input  logic bak_clk,
    input  logic rst_n,
    input  logic pll_mode,
    input  logic det_en,
    output logic sys_clk,
    output logic limp,
    output logic loc_pulse,
    output logic pll_unlocked
);
    act_stat_t act_stat;
    logic      pri_alive;
    logic      pri_sel;
    logic      bak_sel;
    clk_src_e  cur_src;

    loc_activity_mon #(
        .LOC_TIMEOUT (LOC_TIMEOUT)
    ) u_mon (
        .bak_clk (bak_clk),
        .pri_clk (pri_clk),
        .rst_n   (rst_n),
        .stat    (act_stat)
    );

    loc_ctrl #(
        .RECOVER_HS (RECOVER_HS),
        .RELOCK_CYC (RELOCK_CYC)
    ) u_ctrl (
        .bak_clk      (bak_clk),
        .rst_n        (rst_n),
        .det_en       (det_en),
        .pll_mode     (pll_mode),
        .stat         (act_stat),
        .alive        (pri_alive),
        .limp         (limp),
        .loc_pulse    (loc_pulse),
        .pll_unlocked (pll_unlocked)
    );

    loc_glitchfree_mux u_mux (
        .pri_clk  (pri_clk),
        .bak_clk  (bak_clk),
        .rst_n    (rst_n),
        .want_pri (pri_alive),
        .sys_clk  (sys_clk),
        .pri_sel  (pri_sel),
        .bak_sel  (bak_sel)
    );

    // Source currently gated onto the system clock, for the checks below.
    assign cur_src = pri_sel ? SRC_PRIMARY : SRC_BACKUP;

    AST_PULSE_LEAVES_PRIMARY: assert property (@(posedge bak_clk) disable iff (!rst_n)
        loc_pulse |-> (cur_src == SRC_BACKUP));  // R3
    AST_UNLOCK_NOT_BACKUP: assert property (@(posedge bak_clk) disable iff (!rst_n)
        pll_unlocked |-> !bak_sel || pri_alive);  // R7

endmodule

// File: tb/clk_loss_failover_tb.sv
`timescale 1ns/1ps
module clk_loss_failover_tb;
    localparam int  LOC_TIMEOUT = 8;
    localparam int  RECOVER_HS  = 2;
    localparam int  RELOCK_CYC  = 16;
    localparam real BAK_HALF    = 2.5;   // 200 MHz
    localparam real PRI_HALF    = 1.5;
    localparam real MIN_PHASE   = 1.4;

    logic pri_clk = 1'b0;
    logic bak_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic pll_mode = 1'b0;
    logic det_en  = 1'b1;
    logic pri_run = 1'b1;
    logic sys_clk, limp, loc_pulse, pll_unlocked;

    int n_chk = 0, n_fail = 0;
    int sys_cnt = 0, pri_cnt = 0, bak_cnt = 0;
    int pulse_rise = 0, pulse_cyc = 0, unl_cyc = 0, glitch_cnt = 0;
    logic pulse_q = 1'b0;
    realtime last_edge = 0.0;

    clk_loss_failover #(
        .LOC_TIMEOUT (LOC_TIMEOUT),
        .RECOVER_HS  (RECOVER_HS),
        .RELOCK_CYC  (RELOCK_CYC)
    ) u_dut (
        .pri_clk      (pri_clk),
        .bak_clk      (bak_clk),
        .rst_n        (rst_n),
        .pll_mode     (pll_mode),
        .det_en       (det_en),
        .sys_clk      (sys_clk),
        .limp         (limp),
        .loc_pulse    (loc_pulse),
        .pll_unlocked (pll_unlocked)
    );

    always #(BAK_HALF) bak_clk = ~bak_clk;
    always begin
        #(PRI_HALF);
        if (pri_run) pri_clk = ~pri_clk;
    end

    always @(posedge sys_clk) sys_cnt++;
    always @(posedge pri_clk) pri_cnt++;
    always @(posedge bak_clk) bak_cnt++;

    // Sample the backup-domain outputs away from the rising edge.
    always @(negedge bak_clk) begin
        if (loc_pulse) pulse_cyc++;
        if (loc_pulse && !pulse_q) pulse_rise++;
        pulse_q = loc_pulse;
        if (pll_unlocked) unl_cyc++;
    end

    // Runt-phase monitor on the system clock (R9).
    always @(sys_clk) begin
        if ($realtime > 20.0 && ($realtime - last_edge) < MIN_PHASE) glitch_cnt++;
        last_edge = $realtime;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_bak(input int n);
        repeat (n) @(posedge bak_clk);
        #1;
    endtask

    // Compare system clock edges with the expected source over 120 ns.
    task automatic check_src(input bit exp_pri, input string tag);
        int s0, p0, b0, ds, ref_cnt;
        s0 = sys_cnt; p0 = pri_cnt; b0 = bak_cnt;
        #120;
        ds = sys_cnt - s0;
        ref_cnt = exp_pri ? (pri_cnt - p0) : (bak_cnt - b0);
        check(ds >= ref_cnt - 1 && ds <= ref_cnt + 1, tag, ds, ref_cnt);
    endtask

    task automatic stall_pri(input bit lvl, input int dur);
        wait (pri_clk == lvl);
        pri_run = 1'b0;
        #(dur * 2.0 * BAK_HALF);
        pri_run = 1'b1;
    endtask

    initial begin
        #500000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seen_loss;
        int durs[5];
        durs = '{1, 2, 12, 16, 20};
        seen_loss = 0;

        // R1: backup clock during reset, quiet flags.
        wait_bak(5);
        check_src(1'b0, "R1 sys_clk follows backup in reset");
        check(limp == 1'b0, "R1 limp after reset", int'(limp), 0);
        check(loc_pulse == 1'b0, "R1 loc_pulse after reset", int'(loc_pulse), 0);
        check(pll_unlocked == 1'b0, "R1 pll_unlocked after reset", int'(pll_unlocked), 0);
        @(negedge bak_clk);
        rst_n = 1'b1;

        // R2: hand-over to primary; R7: no unlock window on first start.
        wait_bak(60);
        check_src(1'b1, "R2 sys_clk follows primary");
        check(pulse_rise == 0, "R1 no loss event at start", pulse_rise, 0);
        check(unl_cyc == 0, "R7 no unlock window at first start", unl_cyc, 0);
        check(limp == 1'b0, "R5 limp low before any loss", int'(limp), 0);

        // R8: detection disabled, long stall is ignored.
        begin
            int p0, s0;
            det_en = 1'b0;
            p0 = pulse_rise;
            wait (pri_clk == 1'b0);
            pri_run = 1'b0;
            s0 = sys_cnt;
            #150;
            check(sys_cnt == s0, "R8 sys_clk stays on stalled primary", sys_cnt - s0, 0);
            pri_run = 1'b1;
            wait_bak(40);
            check(pulse_rise == p0, "R8 no loss event when disabled", pulse_rise - p0, 0);
            check(limp == 1'b0, "R8 limp unchanged when disabled", int'(limp), 0);
            det_en = 1'b1;
            check_src(1'b1, "R8 still on primary");
        end

        // R3 R4 R5 R6 R7 R10: sweep of mode, stop level and stall length.
        for (int m = 0; m < 2; m++) begin
            for (int lv = 0; lv < 2; lv++) begin
                for (int di = 0; di < 5; di++) begin
                    int p0, c0, u0, exp_loss, exp_unl;
                    pll_mode = m[0];
                    p0 = pulse_rise; c0 = pulse_cyc; u0 = unl_cyc;
                    stall_pri(lv[0], durs[di]);
                    wait_bak(80);
                    exp_loss = (durs[di] >= 12) ? 1 : 0;
                    if (exp_loss == 1) seen_loss = 1;
                    exp_unl = (exp_loss == 1 && m == 1) ? RELOCK_CYC : 0;
                    check(pulse_rise - p0 == exp_loss, "R3 R10 loss events for stall",
                          pulse_rise - p0, exp_loss);
                    check(pulse_cyc - c0 == exp_loss, "R4 loc_pulse width",
                          pulse_cyc - c0, exp_loss);
                    check(unl_cyc - u0 == exp_unl, "R7 pll_unlocked cycles",
                          unl_cyc - u0, exp_unl);
                    check(int'(limp) == seen_loss, "R5 limp sticky", int'(limp), seen_loss);
                    check_src(1'b1, "R6 back on primary");
                end
            end
        end
        check(glitch_cnt == 0, "R9 no runt phase during sweep", glitch_cnt, 0);

        // R1 R2 R5 R7: reset with primary absent, then late primary start.
        begin
            int u0;
            pri_run = 1'b0;
            #10;
            rst_n = 1'b0;
            wait_bak(10);
            @(negedge bak_clk);
            rst_n = 1'b1;
            wait_bak(10);
            check_src(1'b0, "R1 backup while primary absent");
            check(limp == 1'b0, "R5 limp cleared by reset", int'(limp), 0);
            u0 = unl_cyc;
            pri_run = 1'b1;
            wait_bak(80);
            check_src(1'b1, "R2 hand-over after late start");
            check(unl_cyc - u0 == 0, "R7 no unlock window after reset start", unl_cyc - u0, 0);
        end
        check(glitch_cnt == 0, "R9 no runt phase overall", glitch_cnt, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule